// File: doc/BRIEF.md
# Bridge Output Fault Lockout Controller

This block decides, cycle by cycle, whether the output stages of a bridge driver may conduct or must sit in high impedance. It takes already digitised fault indicators, the two enable pins of the driver, and a configuration bit that turns the second enable pin into an open-drain status flag. From these it produces one output-enable per channel, a pull-down request for the shared status pin, and a single-cycle request that tells the register block to set its lock flag.

Faults fall into two classes. Overcurrent or shorted load, overtemperature, logic-supply overvoltage and undervoltage, and ground loss are sticky. They hold the outputs off until the host re-enables the device with a specific pin edge. Load-supply and charge-pump undervoltage are transient. They hold the outputs off only while the condition is present, and the outputs resume without any host action.

Each fault input passes a persistence filter of `FILT` cycles. The enable pins pass two-flop synchronisers, and edges are detected on the synchronised copies.

Top module: `fault_lockout_ctrl`

## Requirements
- R1: After reset, with EN low, every bit of `out_en_o` is 0, `lock_set_o` is 0, and `sf_pull_o` equals `sf_mode_i`.
- R2: With `sf_mode_i`=0 and no fault, `out_en_o` equals `ch_en_i` when EN is high and DIS/SF is low. In every other EN/DIS combination it is all zeros.
- R3: Any one of the five sticky faults, once it has held for `FILT` cycles, forces `out_en_o` to all zeros. It also raises `lock_set_o` for exactly one cycle.
- R4: Outputs stay off after a sticky fault clears. A rising EN while DIS/SF is low (or while `sf_mode_i`=1) returns the block to normal operation.
- R5: With `sf_mode_i`=0, a falling edge on DIS/SF while EN is high also returns the block to normal operation.
- R6: A re-enable edge that arrives while a sticky fault is still asserted leaves the outputs off. After that fault clears, outputs remain off until a new re-enable edge.
- R7: Load-supply or charge-pump undervoltage turns all outputs off only while present. Outputs resume on their own afterwards, and `lock_set_o` is never raised for it.
- R8: When a sticky and a transient fault are present together, the lockout is sticky. Clearing both still requires a re-enable edge.
- R9: With `sf_mode_i`=1, `sf_pull_o` is 1 exactly while EN is low and no fault is present, and DIS/SF has no disabling effect on `out_en_o`. With `sf_mode_i`=0, `sf_pull_o` is always 0.
- R10: With `sf_mode_i`=1, a sticky fault holds `sf_pull_o` at 1 until re-enable. A transient undervoltage sets it only until the supply recovers.
- R11: A fault pulse shorter than `FILT` cycles has no effect on `out_en_o` or `lock_set_o`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| en_i | input | 1 | EN pin level, asynchronous |
| dis_i | input | 1 | DIS/SF pin level as read back, asynchronous |
| sf_mode_i | input | 1 | 1: DIS/SF acts as a status flag output |
| ch_en_i | input | NCH | Per-channel enable from configuration |
| oc_i | input | 1 | Overcurrent or shorted load |
| ot_i | input | 1 | Overtemperature |
| vcc_uv_i | input | 1 | Logic supply undervoltage |
| vcc_ov_i | input | 1 | Logic supply overvoltage |
| gnd_loss_i | input | 1 | Ground loss |
| vs_uv_i | input | 1 | Load supply undervoltage |
| cp_uv_i | input | 1 | Charge pump undervoltage |
| out_en_o | output | NCH | Per-channel output enable (0 = high impedance) |
| sf_pull_o | output | 1 | Pull DIS/SF pin low |
| lock_set_o | output | 1 | One-cycle request to set the lock flag |

## Verification
The enable logic is swept over all EN, DIS/SF and channel-enable combinations in both pin modes. This separates the disable role of DIS/SF from its flag role.

Each sticky fault is applied alone and cleared, then recovered alternately by the EN edge and the DIS/SF edge. This shows that each fault class is routed to the sticky path and that both recovery edges work.

Three further patterns are applied. A re-enable edge arrives while a sticky fault is still asserted. A sticky fault overlaps a transient one. Fault pulses are kept one cycle short of the filter length. These distinguish a correct lockout from one that is level-sensitive, one that lets the transient fault take priority, and one whose filter is too short.

// File: rtl/fault_lockout_ctrl.sv
module fault_lockout_ctrl #(
  parameter int NCH  = 2,
  parameter int FILT = 3
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           en_i,
  input  logic           dis_i,
  input  logic           sf_mode_i,
  input  logic [NCH-1:0] ch_en_i,
  input  logic           oc_i,
  input  logic           ot_i,
  input  logic           vcc_uv_i,
  input  logic           vcc_ov_i,
  input  logic           gnd_loss_i,
  input  logic           vs_uv_i,
  input  logic           cp_uv_i,
  output logic [NCH-1:0] out_en_o,
  output logic           sf_pull_o,
  output logic           lock_set_o
);
  localparam int NF = 7;
  localparam int CW = (FILT > 1) ? $clog2(FILT) : 1;

  typedef enum logic {RUN, LOCK} st_t;

  logic [NF-1:0] raw, flt;
  assign raw = {cp_uv_i, vs_uv_i, gnd_loss_i, vcc_ov_i, vcc_uv_i, ot_i, oc_i};

  for (genvar i = 0; i < NF; i++) begin : g_filt
    logic          f_q;
    logic [CW-1:0] cnt;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        f_q <= 1'b0;
        cnt <= '0;
      end else if (raw[i] != f_q) begin
        if (cnt == CW'(FILT - 1)) begin
          f_q <= raw[i];
          cnt <= '0;
        end else begin
          cnt <= cnt + 1'b1;
        end
      end else begin
        cnt <= '0;
      end
    end
    assign flt[i] = f_q;
  end

  logic [1:0] en_sy, dis_sy;
  logic       en_d, dis_d;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en_sy  <= '0;
      dis_sy <= '0;
      en_d   <= 1'b0;
      dis_d  <= 1'b0;
    end else begin
      en_sy  <= {en_sy[0], en_i};
      dis_sy <= {dis_sy[0], dis_i};
      en_d   <= en_sy[1];
      dis_d  <= dis_sy[1];
    end
  end

  logic en_s, dis_s, lat_f, uv_f, pin_ok, recover;
  assign en_s    = en_sy[1];
  assign dis_s   = dis_sy[1];
  assign lat_f   = |flt[4:0];
  assign uv_f    = |flt[6:5];
  assign pin_ok  = en_s & (sf_mode_i | ~dis_s);
  assign recover = (en_s & ~en_d & (sf_mode_i | ~dis_s))
                 | (~sf_mode_i & en_s & dis_d & ~dis_s);

  st_t st;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st         <= RUN;
      lock_set_o <= 1'b0;
    end else begin
      lock_set_o <= (st == RUN) & lat_f;
      if (st == RUN && lat_f)
        st <= LOCK;
      else if (st == LOCK && recover && !lat_f)
        st <= RUN;
    end
  end

  assign out_en_o  = (st == RUN && !lat_f && !uv_f && pin_ok) ? ch_en_i : '0;
  assign sf_pull_o = sf_mode_i & (~en_s | (st == LOCK) | lat_f | uv_f);
endmodule

// File: rtl/fault_lockout_chk.sv
module fault_lockout_chk #(
  parameter int NCH = 2
) (
  input logic           clk,
  input logic           rst_n,
  input logic           sf_mode_i,
  input logic [NCH-1:0] ch_en_i,
  input logic [NCH-1:0] out_en_o,
  input logic           sf_pull_o,
  input logic           lock_set_o,
  input logic           en_s
);
  // R3
  lock_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    lock_set_o |=> !lock_set_o);
  // R3
  lock_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
    lock_set_o |-> (out_en_o == '0));
  // R2
  ch_mask_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (out_en_o & ~ch_en_i) == '0);
  // R2
  en_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (out_en_o != '0) |-> en_s);
  // R9
  sf_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (sf_mode_i && !en_s) |-> sf_pull_o);
  // R9
  no_sf_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !sf_mode_i |-> !sf_pull_o);
endmodule

bind fault_lockout_ctrl fault_lockout_chk #(.NCH(NCH)) u_chk (
  .clk(clk), .rst_n(rst_n), .sf_mode_i(sf_mode_i), .ch_en_i(ch_en_i),
  .out_en_o(out_en_o), .sf_pull_o(sf_pull_o), .lock_set_o(lock_set_o),
  .en_s(en_s)
);

// File: tb/test_fault_lockout_ctrl.sv
`timescale 1ns/1ps
module test_fault_lockout_ctrl;
  localparam int NCH  = 2;
  localparam int FILT = 3;
  localparam int WF   = FILT + 2;

  logic clk = 1'b0, rst_n = 1'b0;
  logic en = 0, dis = 0, sfm = 0;
  logic [NCH-1:0] ch = '0;
  logic [6:0] flt = '0;
  logic [NCH-1:0] out_en;
  logic sf_pull, lock_set;
  int checks = 0, errors = 0, lock_cnt = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  fault_lockout_ctrl #(.NCH(NCH), .FILT(FILT)) i_fault_lockout_ctrl (
    .clk(clk), .rst_n(rst_n), .en_i(en), .dis_i(dis), .sf_mode_i(sfm),
    .ch_en_i(ch), .oc_i(flt[0]), .ot_i(flt[1]), .vcc_uv_i(flt[2]),
    .vcc_ov_i(flt[3]), .gnd_loss_i(flt[4]), .vs_uv_i(flt[5]), .cp_uv_i(flt[6]),
    .out_en_o(out_en), .sf_pull_o(sf_pull), .lock_set_o(lock_set));

  always @(negedge clk) if (rst_n && lock_set) lock_cnt++;

  task automatic step(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic check(string req, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic summary();
    if (!done) begin
      done = 1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  endtask

  task automatic rec_en();
    en = 0; step(4); en = 1; step(4);
  endtask

  task automatic rec_dis();
    dis = 1; step(4); dis = 0; step(4);
  endtask

  initial begin
    #200000;
    errors++;
    $display("FAIL watchdog actual=0 expected=1");
    summary();
  end

  initial begin
    int lc;
    ch = 2'b11;
    step(3); rst_n = 1; step(1);
    // R1
    check("R1 out_en", int'(out_en), 0);
    check("R1 lock_set", int'(lock_set), 0);
    check("R1 sf_pull", int'(sf_pull), 0);

    // R2 / R9 sweep over both modes, EN, DIS and channel enables
    for (int m = 0; m < 2; m++)
      for (int e = 0; e < 2; e++)
        for (int d = 0; d < 2; d++)
          for (int c = 0; c < 4; c++) begin
            sfm = m[0]; en = e[0]; dis = d[0]; ch = c[NCH-1:0];
            step(4);
            check(m ? "R9 out_en" : "R2 out_en", int'(out_en),
                  (e == 1 && (m == 1 || d == 0)) ? c : 0);
            check("R9 sf_pull", int'(sf_pull), (m == 1 && e == 0) ? 1 : 0);
          end
    sfm = 0; en = 1; dis = 0; ch = 2'b10; step(4);

    // R3 / R4 / R5 each sticky fault, alternate recovery edge
    for (int f = 0; f < 5; f++) begin
      lc = lock_cnt;
      flt[f] = 1; step(WF);
      check("R3 out_off", int'(out_en), 0);
      check("R3 one pulse", lock_cnt - lc, 1);
      flt[f] = 0; step(WF);
      check("R4 held", int'(out_en), 0);
      if (f % 2 == 0) begin
        rec_en();
        check("R4 en recover", int'(out_en), 2);
      end else begin
        rec_dis();
        check("R5 dis recover", int'(out_en), 2);
      end
    end

    // R6 re-enable with fault still active
    flt[1] = 1; step(WF);
    rec_en();
    check("R6 still locked", int'(out_en), 0);
    rec_dis();
    check("R6 still locked dis", int'(out_en), 0);
    flt[1] = 0; step(WF);
    check("R6 no edge", int'(out_en), 0);
    rec_en();
    check("R6 recover", int'(out_en), 2);

    // R7 transient undervoltage
    for (int f = 5; f < 7; f++) begin
      lc = lock_cnt;
      flt[f] = 1; step(WF);
      check("R7 off", int'(out_en), 0);
      flt[f] = 0; step(WF);
      check("R7 resume", int'(out_en), 2);
      check("R7 no lock", lock_cnt - lc, 0);
    end

    // R8 sticky plus transient together
    lc = lock_cnt;
    flt[5] = 1; flt[0] = 1; step(WF);
    check("R8 off", int'(out_en), 0);
    flt[5] = 0; step(WF);
    check("R8 held uv gone", int'(out_en), 0);
    flt[0] = 0; step(WF);
    check("R8 held", int'(out_en), 0);
    check("R8 one pulse", lock_cnt - lc, 1);
    rec_en();
    check("R8 recover", int'(out_en), 2);

    // R11 short pulses
    for (int f = 0; f < 7; f++) begin
      lc = lock_cnt;
      flt[f] = 1; step(FILT - 1); flt[f] = 0; step(WF);
      check("R11 out", int'(out_en), 2);
      check("R11 lock", lock_cnt - lc, 0);
    end

    // R10 status flag mode
    sfm = 1; step(4);
    check("R10 sf idle", int'(sf_pull), 0);
    flt[3] = 1; step(WF);
    check("R10 sf sticky", int'(sf_pull), 1);
    flt[3] = 0; step(WF);
    check("R10 sf held", int'(sf_pull), 1);
    check("R10 out held", int'(out_en), 0);
    rec_en();
    check("R10 sf released", int'(sf_pull), 0);
    check("R10 out back", int'(out_en), 2);
    flt[6] = 1; step(WF);
    check("R10 sf uv", int'(sf_pull), 1);
    flt[6] = 0; step(WF);
    check("R10 sf uv clear", int'(sf_pull), 0);
    check("R10 out uv clear", int'(out_en), 2);

    summary();
  end
endmodule